// File: doc/BRIEF.md
# Policy-Controlled Set-Associative Cache

This block is a small set-associative data cache. It sits between a processor-side word request port and a main-memory word port. Every request carries a word address, a read/write flag, write data and two page-level policy bits. One bit marks the page as not cacheable. The other forces write-through for the page. Two global inputs turn caching on or off and select write-back or write-through as the default. The effective policy for each access combines the global and page controls. A non-cacheable access is a single-word memory transaction and does not touch the cache. A cacheable access is looked up by comparing tags in parallel across every way of one set.

Addresses count 32-bit words. The low bits select the word within a line, the next bits select the set, and the remaining high bits form the tag. A miss allocates a line for reads and for writes. A dirty victim is copied back first, then the whole line is fetched. Lookup then restarts and completes as a hit. Only one request is in flight at a time. The request port is not ready while a request is pending. Each request ends with a one-cycle response pulse, for writes as well as reads.

Top module: `setcache`

## Requirements
- R1: With default parameters the word address splits, from most to least significant, into tag (bits 31:6), set index (bits 5:2) and word offset (bits 1:0). Four lines with different tags and the same set index are all resident at once.
- R2: A read that hits returns the stored word and causes no main-memory transaction.
- R3: A read miss fetches the whole line with one memory read per word, offsets 0,1,2,3 in that order. It then returns the requested word. Later reads of other words in that line hit.
- R4: A write hit under write-back (global write-back, page write-through bit 0) updates only the cache. Main memory keeps its old value, and a later read returns the new word.
- R5: With the global write mode at write-through, a cacheable write updates the line and issues exactly one memory write of the word.
- R6: The page write-through bit set to 1 forces a single-word memory write even when the global mode is write-back.
- R7: When the chosen victim is dirty, its four words are written to memory before the new line is fetched. The memory then holds the data last written to that line. A clean victim causes no memory write.
- R8: With the global cache enable at 0, each access is exactly one memory transaction at its own address, and repeating it is again a memory transaction.
- R9: A request with the page no-cache bit set to 1 bypasses the cache in the same way, even when caching is globally enabled.
- R10: A miss fills an invalid way first. Once the set is full, the victim follows a per-set binary-tree pseudo-LRU that every hit updates. After ways 0..3 are filled in order and way 0 is read again, the next miss in that set evicts way 2.
- R11: After reset, the request port is ready and neither a response nor a memory request is active. While a memory transaction is outstanding the request port is not ready. A memory request holds its address steady until accepted. Every request gets exactly one single-cycle response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_on | input | 1 | Global enable; 0 sends every access to memory |
| wback_mode | input | 1 | Global write mode: 1 write-back, 0 write-through |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Word address |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| req_nocache | input | 1 | Page no-cache bit: forces bypass |
| req_wthru | input | 1 | Page write-through bit |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid on reads |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts (and, for reads, returns data) this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid when mem_ready is high on a read |

## Verification
The bench counts memory handshakes around each request. A design that still touched memory on a read hit, or on a write-back write hit, shows a nonzero count. A design that refilled a line it should already hold also shows one. One set is filled with four tags and one way is touched again. The next miss must evict way 2, so a wrong tree update shows up as an extra miss on the wrong tag. A set filled entirely with dirty lines must produce four write-backs before the fill. The data written back must match what was written, which catches victim or ordering mistakes. Randomized traffic mixes both write modes, the page bits and bypass accesses, and every read is compared with a reference array. Lost dirty data or a stale line shows up as a read mismatch.

// File: rtl/setcache_pkg.sv
package setcache_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_RDOUT, S_WTMEM, S_WBRD, S_WBWR, S_FILL, S_BYP
  } cst_t;
endpackage

// File: rtl/setcache_ram.sv
module setcache_ram #(
  parameter int ABITS = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ABITS-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [ABITS-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << ABITS;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/setcache_plru.sv
module setcache_plru #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    touch,
  input  logic [$clog2(SETS)-1:0] tset,
  input  logic [$clog2(WAYS)-1:0] tway,
  input  logic [$clog2(SETS)-1:0] vset,
  output logic [$clog2(WAYS)-1:0] vway
);
  localparam int WAYW = $clog2(WAYS);
  logic [WAYS-1:0] tree [SETS];
  logic [WAYS-1:0] nxt;

  // each node bit points toward the less recently used half
  always_comb begin
    logic [WAYW:0] n;
    logic b;
    nxt = tree[tset];
    n = (WAYW+1)'(1);
    for (int l = 0; l < WAYW; l++) begin
      b = tway[WAYW-1-l];
      nxt[n[WAYW-1:0]] = ~b;
      n = {n[WAYW-1:0], b};
    end
  end

  always_comb begin
    logic [WAYW:0] n;
    logic b;
    logic [WAYS-1:0] t;
    t = tree[vset];
    n = (WAYW+1)'(1);
    vway = '0;
    for (int l = 0; l < WAYW; l++) begin
      b = t[n[WAYW-1:0]];
      vway[WAYW-1-l] = b;
      n = {n[WAYW-1:0], b};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree[s] <= '0;
    end else if (touch) begin
      tree[tset] <= nxt;
    end
  end
endmodule

// File: rtl/setcache.sv
module setcache #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int WPL  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cache_on,
  input  logic          wback_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_nocache,
  input  logic          req_wthru,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import setcache_pkg::*;

  localparam int OFFW = $clog2(WPL);
  localparam int IDXW = $clog2(SETS);
  localparam int WAYW = $clog2(WAYS);
  localparam int TAGW = AW - IDXW - OFFW;
  localparam int RAMA = WAYW + IDXW + OFFW;
  localparam logic [OFFW-1:0] LASTW = OFFW'(WPL - 1);

  cst_t st;
  logic [AW-1:0]   r_addr;
  logic [DW-1:0]   r_wdata;
  logic            r_we, r_wt;
  logic [OFFW-1:0] cnt;
  logic [WAYW-1:0] vway_r;

  logic [TAGW-1:0] tag_a [WAYS][SETS];
  logic [WAYS-1:0][SETS-1:0] vld, dty;

  logic [TAGW-1:0] a_tag;
  logic [IDXW-1:0] a_idx;
  logic [OFFW-1:0] a_off;
  assign a_tag = r_addr[AW-1 -: TAGW];
  assign a_idx = r_addr[OFFW +: IDXW];
  assign a_off = r_addr[OFFW-1:0];

  logic [WAYS-1:0] hitv;
  logic            hit, inv_any;
  logic [WAYW-1:0] hway, inv_way, plru_way, vict;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hitv[g] = vld[g][a_idx] && (tag_a[g][a_idx] == a_tag);
  end

  always_comb begin
    hit = 1'b0; hway = '0; inv_any = 1'b0; inv_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hitv[w]) begin hit = 1'b1; hway = WAYW'(w); end
      if (!vld[w][a_idx]) begin inv_any = 1'b1; inv_way = WAYW'(w); end
    end
    vict = inv_any ? inv_way : plru_way;
  end

  setcache_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk(clk), .rst(rst), .touch(st == S_LOOK && hit), .tset(a_idx),
    .tway(hway), .vset(a_idx), .vway(plru_way)
  );

  logic            ram_we, ram_re;
  logic [RAMA-1:0] ram_wa, ram_ra;
  logic [DW-1:0]   ram_wd, ram_q;

  always_comb begin
    ram_we = 1'b0; ram_re = 1'b0;
    ram_wa = {hway, a_idx, a_off}; ram_ra = {hway, a_idx, a_off};
    ram_wd = r_wdata;
    case (st)
      S_LOOK: if (hit) begin ram_re = !r_we; ram_we = r_we; end
      S_WBRD: begin ram_re = 1'b1; ram_ra = {vway_r, a_idx, cnt}; end
      S_FILL: begin
        ram_we = mem_ready; ram_wa = {vway_r, a_idx, cnt}; ram_wd = mem_rdata;
      end
      default: ;
    endcase
  end

  setcache_ram #(.ABITS(RAMA), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .re(ram_re), .raddr(ram_ra), .rdata(ram_q)
  );

  always_comb begin
    mem_valid = 1'b0; mem_we = 1'b0; mem_addr = r_addr; mem_wdata = r_wdata;
    case (st)
      S_WTMEM: begin mem_valid = 1'b1; mem_we = 1'b1; end
      S_BYP:   begin mem_valid = 1'b1; mem_we = r_we; end
      S_WBWR:  begin
        mem_valid = 1'b1; mem_we = 1'b1;
        mem_addr = {tag_a[vway_r][a_idx], a_idx, cnt}; mem_wdata = ram_q;
      end
      S_FILL:  begin mem_valid = 1'b1; mem_addr = {a_tag, a_idx, cnt}; end
      default: ;
    endcase
  end

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ready && cnt == LASTW) tag_a[vway_r][a_idx] <= a_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; vld <= '0; dty <= '0; rsp_valid <= 1'b0; rsp_rdata <= '0;
      r_addr <= '0; r_wdata <= '0; r_we <= 1'b0; r_wt <= 1'b0;
      cnt <= '0; vway_r <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          r_addr <= req_addr; r_we <= req_we; r_wdata <= req_wdata;
          r_wt <= !wback_mode || req_wthru;
          st <= (!cache_on || req_nocache) ? S_BYP : S_LOOK;
        end
        S_LOOK: if (hit) begin
          if (!r_we) st <= S_RDOUT;
          else if (r_wt) st <= S_WTMEM;
          else begin
            dty[hway][a_idx] <= 1'b1; rsp_valid <= 1'b1; st <= S_IDLE;
          end
        end else begin
          vway_r <= vict; cnt <= '0;
          st <= (vld[vict][a_idx] && dty[vict][a_idx]) ? S_WBRD : S_FILL;
        end
        S_RDOUT: begin rsp_valid <= 1'b1; rsp_rdata <= ram_q; st <= S_IDLE; end
        S_WTMEM: if (mem_ready) begin rsp_valid <= 1'b1; st <= S_IDLE; end
        S_WBRD:  st <= S_WBWR;
        S_WBWR:  if (mem_ready) begin
          cnt <= cnt + 1'b1;
          st <= (cnt == LASTW) ? S_FILL : S_WBRD;
        end
        S_FILL:  if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LASTW) begin
            vld[vway_r][a_idx] <= 1'b1; dty[vway_r][a_idx] <= 1'b0; st <= S_LOOK;
          end
        end
        S_BYP:   if (mem_ready) begin
          rsp_valid <= 1'b1; rsp_rdata <= mem_rdata; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  busy_noaccept_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);
  // R11
  memhold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R2
  rdhit_nomem_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && hit && !r_we) |=> (!mem_valid ##1 rsp_valid));
  // R4
  wbhit_nomem_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && hit && r_we && !r_wt) |=> (rsp_valid && !mem_valid));
  // R3
  fill_order_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FILL && mem_ready && cnt != LASTW) |=>
      (mem_addr[OFFW-1:0] == $past(mem_addr[OFFW-1:0]) + OFFW'(1)));
  // R9
  byp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_BYP) |=> ($stable(vld) && $stable(dty)));
endmodule

// File: tb/setcache_tb.sv
`timescale 1ns/1ps
module setcache_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cache_on = 1'b1, wback_mode = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0, req_nocache = 1'b0, req_wthru = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, mem_valid, mem_we;
  logic mem_ready = 1'b0;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  setcache u_dut (
    .clk(clk), .rst(rst), .cache_on(cache_on), .wback_mode(wback_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .req_nocache(req_nocache),
    .req_wthru(req_wthru), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem_arr [4096];
  logic [31:0] ref_m [4096];
  logic [31:0] rlog [8];
  int n_rd = 0, n_wr = 0, checks = 0, fails = 0;
  bit done = 0;
  int d_rd, d_wr;

  function automatic logic [31:0] initval(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  assign mem_rdata = mem_arr[mem_addr[11:0]];

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready) begin
      if (mem_we) begin mem_arr[mem_addr[11:0]] <= mem_wdata; n_wr = n_wr + 1; end
      else begin rlog[n_rd[2:0]] <= mem_addr; n_rd = n_rd + 1; end
    end
    if (!rst && mem_valid && req_ready) begin
      checks = checks + 1; fails = fails + 1;
      $display("FAIL R11 ready high during memory request: act=1 exp=0");
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [31:0] a, input bit we, input logic [31:0] wd,
                     input bit nc, input bit wt, output logic [31:0] rd);
    int r0, w0;
    r0 = n_rd; w0 = n_wr;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
    req_nocache = nc; req_wthru = wt;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    d_rd = n_rd - r0; d_wr = n_wr - w0;
    if (we && !nc && cache_on) ref_m[a[11:0]] = wd;
    if (we && (nc || !cache_on)) ref_m[a[11:0]] = wd;
  endtask

  initial begin
    void'($urandom(32'd4021));
    for (int i = 0; i < 4096; i++) begin mem_arr[i] = initval(i); ref_m[i] = initval(i); end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] a;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_valid === 1'b0, "R11 reset",
        {29'd0, req_ready, rsp_valid, mem_valid}, 32'h4);

    // R3 read miss: full line fill in offset order
    req(32'h12, 0, 0, 0, 0, rd);
    chk(rd == ref_m[12'h12], "R3 miss data", rd, ref_m[12'h12]);
    chk(d_rd == 4 && d_wr == 0, "R3 fill count", d_rd, 4);
    for (int k = 0; k < 4; k++) begin
      a = rlog[(n_rd - 4 + k) % 8];
      chk(a == 32'h10 + k, "R3 fill order", a, 32'h10 + k);
    end
    // R2 read hit
    req(32'h11, 0, 0, 0, 0, rd);
    chk(rd == ref_m[12'h11] && d_rd == 0 && d_wr == 0, "R2 hit no mem", rd, ref_m[12'h11]);
    // R4 write-back hit
    req(32'h13, 1, 32'hCAFE0013, 0, 0, rd);
    chk(d_wr == 0 && mem_arr[12'h13] == initval(12'h13), "R4 mem untouched",
        mem_arr[12'h13], initval(12'h13));
    req(32'h13, 0, 0, 0, 0, rd);
    chk(rd == 32'hCAFE0013 && d_rd == 0, "R4 readback", rd, 32'hCAFE0013);
    // R5 global write-through
    wback_mode = 1'b0;
    req(32'h11, 1, 32'hBEEF0011, 0, 0, rd);
    chk(d_wr == 1 && mem_arr[12'h11] == 32'hBEEF0011, "R5 wt write", mem_arr[12'h11], 32'hBEEF0011);
    wback_mode = 1'b1;
    // R6 page write-through in write-back mode
    req(32'h10, 1, 32'hF00D0010, 0, 1, rd);
    chk(d_wr == 1 && mem_arr[12'h10] == 32'hF00D0010, "R6 page wt", mem_arr[12'h10], 32'hF00D0010);

    // R1 / R10: set 7, tags 1..4 coexist, then pseudo-LRU victim
    for (int t = 1; t <= 4; t++) req((t << 6) | 32'h1C, 0, 0, 0, 0, rd);
    req((1 << 6) | 32'h1C, 0, 0, 0, 0, rd);
    chk(d_rd == 0, "R1 four tags resident", d_rd, 0);
    req((5 << 6) | 32'h1C, 0, 0, 0, 0, rd);
    chk(d_rd == 4 && d_wr == 0, "R7 clean victim no writeback", d_wr, 0);
    req((1 << 6) | 32'h1C, 0, 0, 0, 0, rd);
    chk(d_rd == 0, "R10 tag1 kept", d_rd, 0);
    req((2 << 6) | 32'h1C, 0, 0, 0, 0, rd);
    chk(d_rd == 0, "R10 tag2 kept", d_rd, 0);
    req((3 << 6) | 32'h1C, 0, 0, 0, 0, rd);
    chk(d_rd == 4 && rd == ref_m[(3 << 6) | 12'h1C], "R10 way2 evicted", d_rd, 4);

    // R7 dirty victim: set 9 full of dirty lines
    for (int t = 1; t <= 4; t++) req((t << 6) | 32'h24, 1, 32'hD0000000 + t, 0, 0, rd);
    req((5 << 6) | 32'h24, 0, 0, 0, 0, rd);
    chk(d_wr == 4 && d_rd == 4, "R7 writeback count", d_wr, 4);
    chk(mem_arr[(1 << 6) | 12'h24] == 32'hD0000001, "R7 writeback data",
        mem_arr[(1 << 6) | 12'h24], 32'hD0000001);
    req((1 << 6) | 32'h24, 0, 0, 0, 0, rd);
    chk(rd == 32'hD0000001, "R7 refetch", rd, 32'hD0000001);

    // R8 global disable
    cache_on = 1'b0;
    req(32'h805, 0, 0, 0, 0, rd);
    chk(d_rd == 1 && rd == ref_m[12'h805], "R8 bypass read", rd, ref_m[12'h805]);
    req(32'h805, 0, 0, 0, 0, rd);
    chk(d_rd == 1, "R8 no caching", d_rd, 1);
    req(32'h805, 1, 32'h12345678, 0, 0, rd);
    chk(d_wr == 1 && mem_arr[12'h805] == 32'h12345678, "R8 bypass write", mem_arr[12'h805], 32'h12345678);
    cache_on = 1'b1;
    // R9 page no-cache
    req(32'h810, 0, 0, 1, 0, rd);
    req(32'h810, 0, 0, 1, 0, rd);
    chk(d_rd == 1 && rd == ref_m[12'h810], "R9 page bypass", d_rd, 1);

    // randomized mix, every read compared against the reference
    for (int i = 0; i < 800; i++) begin
      bit we, nc, wt;
      logic [31:0] wd;
      we = ($urandom % 3) == 0; wd = $urandom;
      wback_mode = $urandom % 2;
      wt = ($urandom % 4) == 0; nc = 1'b0;
      if (($urandom % 5) == 0) begin
        a = 32'h800 | ($urandom % 1024);
        if ($urandom % 2) nc = 1'b1; else cache_on = 1'b0;
      end else begin
        a = (($urandom % 8) << 6) | ($urandom % 64);
      end
      req(a, we, wd, nc, wt, rd);
      cache_on = 1'b1;
      if (!we) chk(rd == ref_m[a[11:0]], "R2 R3 random read", rd, ref_m[a[11:0]]);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule